// File: doc/BRIEF.md
# Instruction Store Programming Port

This block lets a host load an engine's instruction store one instruction at a time through a small register window. The host first writes a control word. Bit 31 of that word turns programming on, and the low bits give the first store address. The host then sends each 40-bit instruction as a pair of 32-bit writes. The first write carries bits 31:0 and is only held. The second write carries bits 39:32 in its low byte. That second write builds the word, adds two even-parity bits, writes the 42-bit result into the store, and advances the address.

The host can read back the control word at any time. When a load runs past the last store location, the address returns to zero. A readback then shows only the enable bit, so the host can stop padding. A separate read port with one cycle of latency gives the engine's fetch logic the full 42-bit word, parity included.

Top module: `ustore_prog_port`

## Requirements
- R1: While reset is high and on the first cycle after it, programming is disabled, the store address is 0, and `host_rvalid` is 0. A readback of the control word then returns 0.
- R2: A write at byte offset 0x000 sets the enable from data bit 31 and the store address from the low log2(DEPTH) data bits. Higher data bits are dropped. A readback at offset 0x000 returns the enable in bit 31 and the address in the low bits, with every other bit zero.
- R3: A write of 0 at offset 0x000 turns programming off, and a later readback returns 0.
- R4: A committed word holds bits 31:0 from the last write at offset 0x004 and bits 39:32 from data bits 7:0 of the write at offset 0x008. Data bits 31:8 of that write are dropped.
- R5: Bit 40 of a stored word makes bits 19:0 plus bit 40 hold an even count of ones. Bit 41 does the same for bits 39:20 plus bit 41.
- R6: While programming is enabled, a write at offset 0x008 stores the word at the current address and then adds one to the address.
- R7: A commit at address DEPTH-1 moves the address to 0 and leaves programming enabled. A readback then returns exactly 0x80000000.
- R8: While programming is disabled, a write at offset 0x008 changes neither the store nor the address.
- R9: A write at offset 0x004 with no following write at 0x008 leaves the store unchanged. The held low half stays in place and is used again by every later write at 0x008 until it is replaced.
- R10: When `fetch_en` is high, `fetch_data` shows all 42 bits of the word at `fetch_addr` one cycle later. When `fetch_en` is low, `fetch_data` keeps its value.
- R11: `host_rvalid` is high exactly one cycle after `host_rd`, and `host_rdata` is updated in that same cycle. A read at 0x004 returns the held low half. A read at any offset other than 0x000 or 0x004 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_off | input | OFF_W | Byte offset of the register being accessed |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| fetch_en | input | 1 | Engine fetch request |
| fetch_addr | input | log2(DEPTH) | Engine fetch address |
| fetch_data | output | 42 | Stored word, parity in bits 41:40 |

## Verification
The bench builds the block with DEPTH set to 16, so the address field is four bits wide. This choice lets a load reach the last location and wrap back to zero within a few writes. It also shows that address bits above the field are dropped when the control word is written. A behavioural model tracks the store, the enable bit, the address and the held low half. It predicts every readback and every fetch, and those predictions are compared with the outputs on every clock. Directed sequences cover the padding word, parity patterns that set both parity bits, an unpaired low write, and upper writes while programming is off.

// File: rtl/ustore_pkg.sv
package ustore_pkg;
  localparam int unsigned INSN_W   = 40;
  localparam int unsigned GRP_W    = 20;
  localparam int unsigned N_GRP    = INSN_W / GRP_W;
  localparam int unsigned WORD_W   = INSN_W + N_GRP;
  localparam int unsigned HOST_W   = 32;
  localparam int unsigned HI_W     = INSN_W - HOST_W;

  // register window byte offsets
  localparam int unsigned CTRL_OFF = 32'h000;
  localparam int unsigned LO_OFF   = 32'h004;
  localparam int unsigned HI_OFF   = 32'h008;

  localparam int unsigned EN_BIT   = 31;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_LO   = 2'd2,
    SEL_HI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ustore_parity_gen.sv
module ustore_parity_gen #(
  parameter int unsigned GRP_W = 20,
  parameter int unsigned N_GRP = 2
) (
  input  logic [GRP_W*N_GRP-1:0]       insn,
  output logic [GRP_W*N_GRP+N_GRP-1:0] word
);
  localparam int unsigned IW = GRP_W * N_GRP;

  logic [N_GRP-1:0] par;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    // even parity: the group plus its bit has an even count of ones
    assign par[g] = ^insn[g*GRP_W +: GRP_W];
  end

  assign word = {par, insn[IW-1:0]};
endmodule

// File: rtl/ustore_addr_ctrl.sv
module ustore_addr_ctrl #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic          ctrl_en_bit,
  input  logic [AW-1:0] ctrl_addr_bits,
  input  logic          commit_req,
  output logic          prog_en,
  output logic [AW-1:0] cur_addr,
  output logic          commit
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] next_addr;

  assign commit    = commit_req & prog_en;
  assign next_addr = (cur_addr == LAST) ? '0 : cur_addr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_en  <= 1'b0;
      cur_addr <= '0;
    end else if (ctrl_wr) begin
      prog_en  <= ctrl_en_bit;
      cur_addr <= ctrl_addr_bits;
    end else if (commit) begin
      cur_addr <= next_addr;
    end
  end
endmodule

// File: rtl/ustore_ram.sv
module ustore_ram #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned DW    = 42
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ustore_host_if.sv
module ustore_host_if
  import ustore_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned AW    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              prog_en,
  input  logic [AW-1:0]     cur_addr,
  output logic              ctrl_wr,
  output logic              hi_wr,
  output logic [INSN_W-1:0] insn,
  output logic [HOST_W-1:0] host_rdata,
  output logic              host_rvalid
);
  reg_sel_e          sel;
  logic [HOST_W-1:0] lo_hold;
  logic [HOST_W-1:0] ctrl_word;
  logic [HOST_W-1:0] rd_word;

  always_comb begin
    if (host_off == OFF_W'(CTRL_OFF))    sel = SEL_CTRL;
    else if (host_off == OFF_W'(LO_OFF)) sel = SEL_LO;
    else if (host_off == OFF_W'(HI_OFF)) sel = SEL_HI;
    else                                 sel = SEL_NONE;
  end

  assign ctrl_wr = host_wr && (sel == SEL_CTRL);
  assign hi_wr   = host_wr && (sel == SEL_HI);
  assign insn    = {host_wdata[HI_W-1:0], lo_hold};

  always_ff @(posedge clk) begin
    if (rst)                           lo_hold <= '0;
    else if (host_wr && sel == SEL_LO) lo_hold <= host_wdata;
  end

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_BIT]   = prog_en;
    ctrl_word[AW-1:0]   = cur_addr;
    case (sel)
      SEL_CTRL: rd_word = ctrl_word;
      SEL_LO:   rd_word = lo_hold;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/ustore_prog_port.sv
module ustore_prog_port
  import ustore_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned OFF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [OFF_W-1:0]         host_off,
  input  logic [31:0]              host_wdata,
  output logic [31:0]              host_rdata,
  output logic                     host_rvalid,
  input  logic                     fetch_en,
  input  logic [$clog2(DEPTH)-1:0] fetch_addr,
  output logic [41:0]              fetch_data
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic              ctrl_wr;
  logic              hi_wr;
  logic              prog_en;
  logic [AW-1:0]     cur_addr;
  logic              mem_we;
  logic [INSN_W-1:0] insn;
  logic [WORD_W-1:0] mem_wdata;

  ustore_host_if #(.OFF_W(OFF_W), .AW(AW)) u_host (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_off    (host_off),
    .host_wdata  (host_wdata),
    .prog_en     (prog_en),
    .cur_addr    (cur_addr),
    .ctrl_wr     (ctrl_wr),
    .hi_wr       (hi_wr),
    .insn        (insn),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  ustore_addr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk            (clk),
    .rst            (rst),
    .ctrl_wr        (ctrl_wr),
    .ctrl_en_bit    (host_wdata[EN_BIT]),
    .ctrl_addr_bits (host_wdata[AW-1:0]),
    .commit_req     (hi_wr),
    .prog_en        (prog_en),
    .cur_addr       (cur_addr),
    .commit         (mem_we)
  );

  ustore_parity_gen #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_par (
    .insn (insn),
    .word (mem_wdata)
  );

  ustore_ram #(.DEPTH(DEPTH), .AW(AW), .DW(WORD_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cur_addr),
    .wdata (mem_wdata),
    .re    (fetch_en),
    .raddr (fetch_addr),
    .rdata (fetch_data)
  );
endmodule

// File: rtl/ustore_prog_port_chk.sv
module ustore_prog_port_chk #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          host_rd,
  input logic          host_rvalid,
  input logic          hi_wr,
  input logic          prog_en,
  input logic [AW-1:0] cur_addr,
  input logic          mem_we,
  input logic [41:0]   mem_wdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!prog_en && cur_addr == '0 && !host_rvalid));

  p_commit_step_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cur_addr != LAST) |=> cur_addr == $past(cur_addr) + AW'(1));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && cur_addr == LAST) |=> (cur_addr == '0 && prog_en));

  p_idle_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !prog_en) |=> ($stable(cur_addr) && !prog_en));

  p_we_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> prog_en);

  p_even_low_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (^{mem_wdata[40], mem_wdata[19:0]}) == 1'b0);

  p_even_high_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (^{mem_wdata[41], mem_wdata[39:20]}) == 1'b0);

  p_rvalid_on_r11: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);

  p_rvalid_off_r11: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);
endmodule

bind ustore_prog_port ustore_prog_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_rd     (host_rd),
  .host_rvalid (host_rvalid),
  .hi_wr       (hi_wr),
  .prog_en     (prog_en),
  .cur_addr    (cur_addr),
  .mem_we      (mem_we),
  .mem_wdata   (mem_wdata)
);

// File: tb/tb_ustore_prog_port.sv
module tb_ustore_prog_port;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [OFF_W-1:0] host_off = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          host_rvalid;
  logic          fetch_en = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [41:0]   fetch_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ustore_prog_port #(.DEPTH(DEPTH), .OFF_W(OFF_W)) dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data)
  );

  // ---------------- behavioural reference model ----------------
  logic [41:0] m_mem [int];
  bit          m_en;
  int          m_addr;
  logic [31:0] m_lo;
  bit          e_rvalid;
  logic [31:0] e_rdata;
  bit          e_fknown;
  logic [41:0] e_fetch;

  function automatic logic [41:0] mkw(input logic [31:0] lo, input logic [7:0] hi);
    logic [39:0] i;
    i = {hi, lo};
    return {^i[39:20], ^i[19:0], i};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_addr = 0; m_lo = '0;
      e_rvalid = 0; e_rdata = '0; e_fknown = 0;
    end else begin
      e_rvalid = host_rd;
      if (host_rd) begin
        if (host_off == 12'h000)      e_rdata = {m_en, 31'(m_addr)};
        else if (host_off == 12'h004) e_rdata = m_lo;
        else                          e_rdata = '0;
      end
      if (fetch_en) begin
        e_fknown = m_mem.exists(int'(fetch_addr));
        if (e_fknown) e_fetch = m_mem[int'(fetch_addr)];
      end
      if (host_wr) begin
        if (host_off == 12'h000) begin
          m_en = host_wdata[31];
          m_addr = int'(host_wdata) % DEPTH;
        end else if (host_off == 12'h004) begin
          m_lo = host_wdata;
        end else if (host_off == 12'h008 && m_en) begin
          m_mem[m_addr] = mkw(m_lo, host_wdata[7:0]);
          m_addr = (m_addr + 1) % DEPTH;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R11 rvalid", 64'(host_rvalid), 64'(e_rvalid));
      if (e_rvalid) chk("R11 rdata", 64'(host_rdata), 64'(e_rdata));
      if (e_fknown) chk("R10 fetch", 64'(fetch_data), 64'(e_fetch));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_off = off; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] off, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_off = off;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic fetch(input int a, output logic [41:0] d);
    @(negedge clk);
    fetch_en = 1'b1; fetch_addr = AW'(a);
    @(negedge clk);
    fetch_en = 1'b0;
    d = fetch_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [41:0] f;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 rvalid after reset", 64'(host_rvalid), 64'd0);
    rd(12'h000, r);  chk("R1 ctrl after reset", 64'(r), 64'h0);

    wr(12'h000, 32'h8000_0003);
    rd(12'h000, r);  chk("R2 ctrl readback", 64'(r), 64'h8000_0003);

    wr(12'h004, 32'h1234_5678);
    wr(12'h008, 32'hFFFF_FFAB);
    rd(12'h000, r);  chk("R6 increment", 64'(r), 64'h8000_0004);
    fetch(3, f);     chk("R4 R5 assembled word", 64'(f), 64'(42'h3_AB12_3456_78));

    wr(12'h004, 32'h0000_0001);
    wr(12'h008, 32'h0000_0080);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0000_00FF);
    fetch(4, f);     chk("R5 both parity set", 64'(f), 64'(42'h3_80_0000_0001));
    fetch(5, f);     chk("R5 all ones", 64'(f), 64'(42'h0_FF_FFFF_FFFF));
    repeat (3) @(negedge clk);
    chk("R10 fetch hold", 64'(fetch_data), 64'(42'h0_FF_FFFF_FFFF));

    wr(12'h000, 32'h8000_0004);
    wr(12'h004, 32'hCAFE_F00D);
    fetch(4, f);     chk("R9 lone low write", 64'(f), 64'(42'h3_80_0000_0001));
    rd(12'h004, r);  chk("R11 R9 held low", 64'(r), 64'hCAFE_F00D);
    wr(12'h008, 32'h0000_005A);
    wr(12'h008, 32'h0000_005B);
    fetch(4, f);     chk("R9 reuse first", 64'(f), 64'(mkw(32'hCAFE_F00D, 8'h5A)));
    fetch(5, f);     chk("R9 reuse second", 64'(f), 64'(mkw(32'hCAFE_F00D, 8'h5B)));
    rd(12'h008, r);  chk("R11 other offset", 64'(r), 64'h0);

    wr(12'h000, 32'h8000_0FF2);
    rd(12'h000, r);  chk("R2 high addr bits dropped", 64'(r), 64'h8000_0002);

    wr(12'h000, 32'h8000_000E);
    wr(12'h004, 32'h0000_1111);
    wr(12'h008, 32'h0000_0011);
    wr(12'h004, 32'h0000_2222);
    wr(12'h008, 32'h0000_0022);
    rd(12'h000, r);  chk("R7 wrap readback", 64'(r), 64'h8000_0000);
    wr(12'h004, 32'h000C_0300);
    wr(12'h008, 32'h0000_00F0);
    fetch(0, f);     chk("R7 pad at zero", 64'(f), 64'(42'h0_F0_000C_0300));
    fetch(15, f);    chk("R6 last location", 64'(f), 64'(mkw(32'h0000_2222, 8'h22)));

    wr(12'h000, 32'h0000_0000);
    rd(12'h000, r);  chk("R3 disabled", 64'(r), 64'h0);
    wr(12'h008, 32'h0000_0077);
    rd(12'h000, r);  chk("R8 addr unchanged", 64'(r), 64'h0);
    fetch(0, f);     chk("R8 store unchanged", 64'(f), 64'(42'h0_F0_000C_0300));

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule